// File: doc/BRIEF.md
# SDRAM Write Burst Sequencer

This block is the device-side half of an SDRAM write path. It watches a two-bit command input. When a write command arrives, it takes the bank and starting column from the address inputs. It then issues one write strobe per clock, with a matching column address, into a small internal word array. The first data word is stored on the same rising edge that registers the command, and one more word is stored on each edge after that.

The burst length comes from a code input. Lengths of 1, 2, 4 and 8 wrap inside their aligned block of columns. Full-page mode keeps running and wraps from the top of the page to column 0. A new write command cuts the running burst short and starts its own burst in the same cycle. A terminate command stops the burst without storing anything on that edge.

When the write command asked for auto-precharge and the burst runs to its natural end, the block raises a one-cycle precharge request naming the bank. The stored words can be read back through a combinational read port.

Top module: `sdram_wr_burst`

## Requirements
- R1: After reset `wr_en`, `busy`, `done` and `pre_req` are low until a write command is presented.
- R2: Command code 2'b01 is WRITE. On the cycle it is presented, `wr_en` is high, `wr_col` equals `cmd_col` and `wr_bank` equals `cmd_bank`. On that same rising edge `din` is stored at that bank and column, and the stored word is readable through `rd_bank`/`rd_col`/`rd_data`.
- R3: `burst_code` selects the length: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8, 7 gives full page, and any other code gives 1 beat. For a fixed length, each later cycle stores one beat, with the column stepping by one and wrapping inside the length-aligned block.
- R4: Once a fixed-length burst has stored its last beat and no new command arrives, `wr_en` stays low and values on `din` are not stored.
- R5: A full-page burst stores one beat per cycle with no limit, and the column wraps from 2^COL_W-1 to 0.
- R6: A WRITE presented during a burst ends that burst at once. In that same cycle the new burst stores its first beat at its own column.
- R7: Command code 2'b10 is TERMINATE. It ends a burst with `wr_en` low in that cycle, so nothing is stored on that edge. Code 2'b00 is NOP.
- R8: If `cmd_autopre` was high on the WRITE and the burst stores its final beat, `pre_req` is high for one cycle in the following cycle, with `pre_bank` equal to the burst's bank. This holds even when a new command follows right after the final beat.
- R9: A burst that is truncated or terminated never raises `pre_req`.
- R10: `done` is high exactly on the cycle the final beat of a fixed-length burst is stored. `busy` is high in each cycle after the WRITE cycle in which the burst still has beats to store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd | input | 2 | 00 NOP, 01 WRITE, 10 TERMINATE, 11 treated as NOP |
| cmd_bank | input | BANK_W | Bank taken with a WRITE |
| cmd_col | input | COL_W | Starting column taken with a WRITE |
| cmd_autopre | input | 1 | Auto-precharge request taken with a WRITE |
| burst_code | input | 3 | Burst length code taken with a WRITE |
| din | input | DATA_W | Write data bus |
| wr_en | output | 1 | A beat is stored on this clock edge |
| wr_bank | output | BANK_W | Bank of the current beat |
| wr_col | output | COL_W | Column of the current beat |
| busy | output | 1 | Burst has beats still pending |
| done | output | 1 | Final beat of a fixed burst this cycle |
| pre_req | output | 1 | Precharge request pulse |
| pre_bank | output | BANK_W | Bank to precharge |
| rd_bank | input | BANK_W | Read-back bank |
| rd_col | input | COL_W | Read-back column |
| rd_data | output | DATA_W | Stored word at the read-back address |

## Verification
`wr_en`, `wr_col`, `wr_bank`, `done` and `busy` are due in the same cycle as the command and data they respond to. The stored word appears on the read port just after the rising edge that stores it. `pre_req` is due one cycle after the final beat. The bench drives inputs on the falling edge and compares the combinational results a short time later, before the next rising edge. It carries the expected precharge pulse forward one step and compares it in the next cycle. At the end it reads back every location the reference model wrote, which also shows that ignored data never reached the array.

// File: rtl/sdram_wr_burst.sv
module sdram_wr_burst #(
  parameter int DATA_W = 16,
  parameter int BANK_W = 2,
  parameter int COL_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cmd,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [COL_W-1:0]  cmd_col,
  input  logic              cmd_autopre,
  input  logic [2:0]        burst_code,
  input  logic [DATA_W-1:0] din,
  output logic              wr_en,
  output logic [BANK_W-1:0] wr_bank,
  output logic [COL_W-1:0]  wr_col,
  output logic              busy,
  output logic              done,
  output logic              pre_req,
  output logic [BANK_W-1:0] pre_bank,
  input  logic [BANK_W-1:0] rd_bank,
  input  logic [COL_W-1:0]  rd_col,
  output logic [DATA_W-1:0] rd_data
);
  localparam int LW    = COL_W + 1;
  localparam int WORDS = 1 << (BANK_W + COL_W);
  localparam logic [1:0] CMD_WR = 2'b01;
  localparam logic [1:0] CMD_BT = 2'b10;

  logic              active_r, full_r, ap_r;
  logic [BANK_W-1:0] bank_r;
  logic [COL_W-1:0]  col_r, mask_r;
  logic [LW-1:0]     left_r;

  logic              is_wr, is_bt, new_full, cur_full, cur_ap, last;
  logic [COL_W-1:0]  new_mask, cur_mask, cur_col, nxt_col;
  logic [LW-1:0]     cur_left;
  logic [BANK_W-1:0] cur_bank;

  always_comb begin
    case (burst_code)
      3'd1:    new_mask = COL_W'(1);
      3'd2:    new_mask = COL_W'(3);
      3'd3:    new_mask = COL_W'(7);
      3'd7:    new_mask = '1;
      default: new_mask = '0;
    endcase
  end

  assign is_wr    = (cmd == CMD_WR);
  assign is_bt    = (cmd == CMD_BT);
  assign new_full = (burst_code == 3'd7);

  assign cur_col  = is_wr ? cmd_col     : col_r;
  assign cur_mask = is_wr ? new_mask    : mask_r;
  assign cur_full = is_wr ? new_full    : full_r;
  assign cur_ap   = is_wr ? cmd_autopre : ap_r;
  assign cur_bank = is_wr ? cmd_bank    : bank_r;
  assign cur_left = is_wr ? ({1'b0, new_mask} + LW'(1)) : left_r;

  assign wr_en   = is_wr | (active_r & ~is_bt);
  assign last    = wr_en & ~cur_full & (cur_left == LW'(1));
  assign nxt_col = (cur_col & ~cur_mask) | ((cur_col + COL_W'(1)) & cur_mask);

  assign wr_col  = cur_col;
  assign wr_bank = cur_bank;
  assign done    = last;
  assign busy    = active_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_r <= 1'b0;
      full_r   <= 1'b0;
      ap_r     <= 1'b0;
      bank_r   <= '0;
      col_r    <= '0;
      mask_r   <= '0;
      left_r   <= '0;
      pre_req  <= 1'b0;
      pre_bank <= '0;
    end else begin
      pre_req  <= last & cur_ap;
      pre_bank <= cur_bank;
      if (wr_en) begin
        active_r <= ~last;
        full_r   <= cur_full;
        ap_r     <= cur_ap;
        bank_r   <= cur_bank;
        col_r    <= nxt_col;
        mask_r   <= cur_mask;
        left_r   <= cur_left - LW'(1);
      end else begin
        active_r <= 1'b0;
      end
    end
  end

  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (wr_en) mem[{cur_bank, cur_col}] <= din;
  end

  assign rd_data = mem[{rd_bank, rd_col}];
endmodule

// File: rtl/sdram_wr_burst_chk.sv
module sdram_wr_burst_chk #(
  parameter int COL_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       cmd,
  input logic [COL_W-1:0] cmd_col,
  input logic             wr_en,
  input logic [COL_W-1:0] wr_col,
  input logic             busy,
  input logic             done,
  input logic             pre_req
);
  AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd != 2'b01) |-> !wr_en); // R4
  AST_WRITE_TAKES_COL: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 2'b01) |-> (wr_en && wr_col == cmd_col)); // R2
  AST_TERM_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 2'b10) |-> !wr_en); // R7
  AST_DONE_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> wr_en); // R10
  AST_MORE_BEATS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !done) |=> busy); // R10
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy); // R4
  AST_PRE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    pre_req |-> $past(done)); // R8
endmodule

bind sdram_wr_burst sdram_wr_burst_chk #(.COL_W(COL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd(cmd), .cmd_col(cmd_col), .wr_en(wr_en),
  .wr_col(wr_col), .busy(busy), .done(done), .pre_req(pre_req)
);

// File: tb/tb_sdram_wr_burst.sv
module tb_sdram_wr_burst;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int BW = 2;
  localparam int CW = 6;
  localparam int PAGE = 1 << CW;
  localparam logic [1:0] NOP = 2'b00, WR = 2'b01, BT = 2'b10;

  logic clk = 0, rst_n = 0;
  logic [1:0] cmd = NOP;
  logic [BW-1:0] cmd_bank = '0, rd_bank = '0, wr_bank, pre_bank;
  logic [CW-1:0] cmd_col = '0, rd_col = '0, wr_col;
  logic cmd_autopre = 0;
  logic [2:0] burst_code = '0;
  logic [DW-1:0] din = '0, rd_data;
  logic wr_en, busy, done, pre_req;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_wr_burst #(.DATA_W(DW), .BANK_W(BW), .COL_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .cmd_bank(cmd_bank), .cmd_col(cmd_col),
    .cmd_autopre(cmd_autopre), .burst_code(burst_code), .din(din),
    .wr_en(wr_en), .wr_bank(wr_bank), .wr_col(wr_col), .busy(busy), .done(done),
    .pre_req(pre_req), .pre_bank(pre_bank), .rd_bank(rd_bank), .rd_col(rd_col),
    .rd_data(rd_data));

  int checks = 0, failures = 0;
  bit m_active = 0, m_full = 0, m_ap = 0, exp_pre = 0;
  int m_bank = 0, m_start = 0, m_base = 0, m_len = 1, m_cnt = 0, exp_pre_bank = 0;
  int data_seq = 16'h1000;
  logic [DW-1:0] mm [int];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int len_of(input int code);
    case (code)
      1: return 2; 2: return 4; 3: return 8; 7: return PAGE;
      default: return 1;
    endcase
  endfunction

  task automatic step(input logic [1:0] c, input int bank = 0, input int col = 0,
                      input bit ap = 0, input int code = 0, input string req = "R3");
    bit e_wr, e_last;
    int e_col, e_bank;
    cmd = c; cmd_bank = BW'(bank); cmd_col = CW'(col); cmd_autopre = ap;
    burst_code = 3'(code); din = DW'(data_seq); data_seq++;
    #1;
    if (c == WR) begin
      m_active = 1; m_full = (code == 7); m_ap = ap; m_bank = bank;
      m_len = len_of(code); m_start = col; m_base = col - (col % m_len); m_cnt = 0;
    end else if (c == BT) begin
      m_active = 0;
    end
    e_wr = m_active;
    e_col = m_base + ((m_start - m_base + m_cnt) % m_len);
    e_bank = m_bank;
    e_last = e_wr && !m_full && (m_cnt == m_len - 1);
    chk(wr_en == e_wr, req, "wr_en", wr_en, e_wr);
    if (e_wr) begin
      chk(wr_col == CW'(e_col), req, "wr_col", wr_col, e_col);
      chk(wr_bank == BW'(e_bank), req, "wr_bank", wr_bank, e_bank);
      mm[e_bank * PAGE + e_col] = din;
    end
    chk(done == e_last, "R10", "done", done, e_last);
    chk(pre_req == exp_pre, "R8/R9", "pre_req", pre_req, exp_pre);
    if (exp_pre) chk(pre_bank == BW'(exp_pre_bank), "R8", "pre_bank", pre_bank, exp_pre_bank);
    exp_pre = e_last && m_ap;
    exp_pre_bank = m_bank;
    if (e_wr) begin
      m_cnt++;
      if (e_last) m_active = 0;
    end
    @(posedge clk); @(negedge clk);
    chk(busy == m_active, "R10", "busy", busy, m_active);
  endtask

  task automatic idle(input int n, input string req);
    for (int i = 0; i < n; i++) step(NOP, 0, 0, 0, 0, req);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(!wr_en && !busy && !done && !pre_req, "R1", "outputs in reset", wr_en, 0);
    rst_n = 1;
    @(negedge clk);
    idle(2, "R1");
    // R2 R3: length 4 from column 5 wraps within block 4..7
    step(WR, 1, 5, 0, 2, "R2"); idle(3, "R3");
    // R4: data after completion is ignored
    idle(3, "R4");
    // R8: length 8 with auto-precharge from column 13
    step(WR, 2, 13, 1, 3, "R2"); idle(7, "R3"); idle(2, "R8");
    // R3: length 1 and length 2, unused code 5 acts as length 1
    step(WR, 0, 9, 1, 0, "R3"); idle(2, "R8");
    step(WR, 3, 3, 0, 1, "R3"); idle(1, "R3"); idle(1, "R4");
    step(WR, 1, 40, 0, 5, "R3"); idle(1, "R4");
    // R5 R7: full page from 60 wraps to 0, then terminate
    step(WR, 3, 60, 1, 7, "R5"); idle(7, "R5"); step(BT, 0, 0, 0, 0, "R7");
    idle(2, "R9");
    // R6 R9: truncation of an auto-precharge burst by a new write
    step(WR, 0, 0, 1, 3, "R6"); idle(2, "R6");
    step(WR, 3, 20, 0, 2, "R6"); idle(5, "R9");
    // R9: terminated auto-precharge burst
    step(WR, 2, 32, 1, 2, "R7"); idle(1, "R7"); step(BT, 0, 0, 0, 0, "R7"); idle(2, "R9");
    // R8: final beat followed at once by a new write still precharges
    step(WR, 1, 50, 1, 1, "R8"); idle(1, "R8");
    step(WR, 2, 44, 0, 0, "R8"); idle(2, "R8");
    // R2 R4: read back every word the model stored
    cmd = NOP;
    foreach (mm[k]) begin
      rd_bank = BW'(k / PAGE); rd_col = CW'(k % PAGE);
      #1;
      chk(rd_data == mm[k], "R2/R4", "stored word", rd_data, mm[k]);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule